// File: doc/BRIEF.md
# Programmable Tap Delay Line

This block delays a single-bit signal by a programmable number of clock cycles. The incoming bit passes through an input register and then through a chain of binary-weighted delay stages. Stage n holds 2^n register elements and is either inserted into the path or bypassed, depending on bit n of a held tap word. With a seven-bit tap word this gives 128 settings. The path length runs from one cycle at tap 0 to 128 cycles at tap 127.

The tap word and one extra cascade bit are captured in a holding register that loads on every clock edge while the load enable is high. It keeps its value while the load enable is low. Two override inputs force the shortest or the longest setting whatever the held word is. The cascade bit is brought out on its own output, one register later, so that a further delay unit can be chained using one extra shared select line. An input enable freezes the input register, so transitions of the data input are not seen while it is low.

Each stage register always shifts the stage's own input, whether the stage is inserted or bypassed. A new setting therefore produces correct output for every transition that enters after the chain has run for 128 cycles under that setting. Transitions already inside the chain when the setting changes may be lost or repeated.

Top module: `prog_delay_line`

## Requirements
- R1: A clock edge with rst_n low clears the held tap word, the held cascade bit, the input register, every stage register and casc_out, so dout and casc_out read 0 after it, even if tap_load is high.
- R2: On a clock edge with tap_load high, the held tap word takes the value of tap_sel and the held cascade bit takes the value of cascade_sel. With tap_load low both keep their value, and changes on tap_sel and cascade_sel have no effect on dout or casc_out.
- R3: The effective tap E is the held tap word unless an override is active. Once E has been constant for at least 128 cycles, dout after clock edge t equals the input register value after edge t-E. A pulse on din that is accepted at an edge appears on dout E+1 edges later. Bit n of E adds 2^n cycles.
- R4: force_min high alone makes E = 0. force_max high makes E = 127 (all ones) whether or not force_min is also high.
- R5: With din_en high the input register loads din at each edge. With din_en low it holds its value, so din transitions in that cycle never reach dout.
- R6: casc_out after edge t equals the held cascade bit as it stood before edge t. A cascade value loaded at one edge therefore appears on casc_out one edge later.
- R7: The total delay is monotonic: a larger tap value never gives a shorter din-to-dout latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| din | input | 1 | Data bit to be delayed |
| din_en | input | 1 | Input enable; low freezes the input register |
| tap_sel | input | SEL_W (7) | Tap word presented to the holding register |
| cascade_sel | input | 1 | Cascade bit presented to the holding register |
| tap_load | input | 1 | Holding register loads while high |
| force_min | input | 1 | Override to the shortest delay |
| force_max | input | 1 | Override to the longest delay; wins over force_min |
| dout | output | 1 | Delayed data bit |
| casc_out | output | 1 | Held cascade bit, one register later |

## Verification
The checker watches, on every cycle, the load and hold behaviour of the tap and cascade register and the load and hold behaviour of the input register. It also checks the one-register alignment of casc_out and that the minimum override connects the input register straight to dout. The delay length for each tap value, the priority of the maximum override, the loss of transitions while the input is disabled, and monotonic latency across tap values all involve windows of up to 128 cycles. These can only be shown by the bench's scenarios: the bench compares dout against a history-based model during long settled runs, and measures single-pulse latency for a ladder of tap values.

// File: rtl/pdl_pkg.sv
// Shared definitions for the programmable tap delay line.
// Assumes: callers pass single-bit override requests.
package pdl_pkg;

    // Which override, if any, decides the effective tap.
    typedef enum logic [1:0] {
        OVR_NONE = 2'd0,
        OVR_MIN  = 2'd1,
        OVR_MAX  = 2'd2
    } ovr_mode_e;

    // The maximum request wins over the minimum request.
    function automatic ovr_mode_e ovr_decode(input logic want_min, input logic want_max);
        if (want_max) return OVR_MAX;
        if (want_min) return OVR_MIN;
        return OVR_NONE;
    endfunction

endpackage

// File: rtl/pdl_sel_latch.sv
// Holding register for the tap word and the cascade bit.
// Loads on every clock edge while load is high and holds while it is low.
// Assumes: synchronous active-low reset clears both fields.
module pdl_sel_latch #(
    parameter int SEL_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SEL_W-1:0] sel_in,
    input  logic             casc_in,
    output logic [SEL_W-1:0] tap_q,
    output logic             casc_q
);

    // Capture the select word while loading, keep it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tap_q  <= '0;
            casc_q <= 1'b0;
        end else if (load) begin
            tap_q  <= sel_in;
            casc_q <= casc_in;
        end
    end

endmodule

// File: rtl/pdl_tap_resolve.sv
// Picks the effective tap from the held word and the two override inputs.
// Purely combinational. Assumes: overrides are already synchronous to clk.
module pdl_tap_resolve #(
    parameter int SEL_W = 7
) (
    input  logic             force_min,
    input  logic             force_max,
    input  logic [SEL_W-1:0] tap_q,
    output logic [SEL_W-1:0] tap_eff
);
    import pdl_pkg::*;

    ovr_mode_e mode;

    // Apply override priority to the held tap word.
    always_comb begin
        mode = ovr_decode(force_min, force_max);
        unique case (mode)
            OVR_MAX: tap_eff = {SEL_W{1'b1}};
            OVR_MIN: tap_eff = '0;
            default: tap_eff = tap_q;
        endcase
    end

endmodule

// File: rtl/pdl_stage.sv
// One binary-weighted delay stage of LEN register elements.
// The shift register always advances with the stage input, so its tail
// holds that input delayed by LEN cycles even while the stage is bypassed.
// Assumes: LEN >= 1.
module pdl_stage #(
    parameter int LEN = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic s_in,
    input  logic insert,
    output logic s_out
);

    logic tail;

    if (LEN == 1) begin : g_single
        logic sr;
        // Single element: one cycle of delay.
        always_ff @(posedge clk) begin
            if (!rst_n) sr <= 1'b0;
            else        sr <= s_in;
        end
        assign tail = sr;
    end else begin : g_multi
        logic [LEN-1:0] sr;
        // Shift the stage input along LEN elements.
        always_ff @(posedge clk) begin
            if (!rst_n) sr <= '0;
            else        sr <= {sr[LEN-2:0], s_in};
        end
        assign tail = sr[LEN-1];
    end

    // Insert the delayed copy or pass the input straight through.
    always_comb begin
        s_out = insert ? tail : s_in;
    end

endmodule

// File: rtl/prog_delay_line.sv
// Programmable tap delay line: an input register followed by SEL_W
// binary-weighted stages, giving a delay of (effective tap + 1) cycles.
// Also carries a held cascade bit to casc_out for chaining units.
// Assumes: all inputs synchronous to clk; a tap change is followed by
// at least 2^SEL_W cycles before transitions that must see the new delay.
module prog_delay_line #(
    parameter int SEL_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din,
    input  logic             din_en,
    input  logic [SEL_W-1:0] tap_sel,
    input  logic             cascade_sel,
    input  logic             tap_load,
    input  logic             force_min,
    input  logic             force_max,
    output logic             dout,
    output logic             casc_out
);

    localparam int CHAIN_N = SEL_W + 1;

    logic [SEL_W-1:0]   tap_q;
    logic [SEL_W-1:0]   tap_eff;
    logic               casc_q;
    logic               in_q;
    logic [CHAIN_N-1:0] link;

    pdl_sel_latch #(.SEL_W(SEL_W)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tap_load),
        .sel_in  (tap_sel),
        .casc_in (cascade_sel),
        .tap_q   (tap_q),
        .casc_q  (casc_q)
    );

    pdl_tap_resolve #(.SEL_W(SEL_W)) u_resolve (
        .force_min (force_min),
        .force_max (force_max),
        .tap_q     (tap_q),
        .tap_eff   (tap_eff)
    );

    // Input register, frozen while the input enable is low.
    always_ff @(posedge clk) begin
        if (!rst_n)      in_q <= 1'b0;
        else if (din_en) in_q <= din;
    end

    assign link[0] = in_q;

    for (genvar n = 0; n < SEL_W; n++) begin : g_stage
        pdl_stage #(.LEN(1 << n)) u_stage (
            .clk    (clk),
            .rst_n  (rst_n),
            .s_in   (link[n]),
            .insert (tap_eff[n]),
            .s_out  (link[n+1])
        );
    end

    assign dout = link[SEL_W];

    // Register the held cascade bit once more for alignment.
    always_ff @(posedge clk) begin
        if (!rst_n) casc_out <= 1'b0;
        else        casc_out <= casc_q;
    end

endmodule

// File: rtl/pdl_checker.sv
// Cycle-level properties of the programmable tap delay line.
// Attached to every prog_delay_line instance through bind below.
module pdl_checker #(
    parameter int SEL_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             din,
    input logic             din_en,
    input logic [SEL_W-1:0] tap_sel,
    input logic             cascade_sel,
    input logic             tap_load,
    input logic             force_min,
    input logic             force_max,
    input logic             dout,
    input logic             casc_out,
    input logic [SEL_W-1:0] tap_q,
    input logic             casc_q,
    input logic             in_q
);

    p_latch_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tap_load |=> (tap_q == $past(tap_sel)) && (casc_q == $past(cascade_sel)));

    p_latch_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tap_load |=> $stable(tap_q) && $stable(casc_q));

    p_min_bypass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (force_min && !force_max) |-> (dout == in_q));

    p_gate_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        din_en |=> (in_q == $past(din)));

    p_gate_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !din_en |=> $stable(in_q));

    p_casc_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (casc_out == $past(casc_q)));

endmodule

bind prog_delay_line pdl_checker #(.SEL_W(SEL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .din         (din),
    .din_en      (din_en),
    .tap_sel     (tap_sel),
    .cascade_sel (cascade_sel),
    .tap_load    (tap_load),
    .force_min   (force_min),
    .force_max   (force_max),
    .dout        (dout),
    .casc_out    (casc_out),
    .tap_q       (tap_q),
    .casc_q      (casc_q),
    .in_q        (in_q)
);

// File: tb/sim_prog_delay_line.sv
`timescale 1ns/1ps
module sim_prog_delay_line;

    logic       clk = 1'b0;
    logic       rst_n, din, din_en, cascade_sel, tap_load, force_min, force_max;
    logic [6:0] tap_sel;
    logic       dout, casc_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Bench model state
    logic [6:0] m_tap;
    logic       m_casc, m_cout, m_in;
    logic       hist [256];
    int         wp = 0;
    int         eff_prev = -1;
    int         settle = 0;

    always #2 clk = ~clk;

    prog_delay_line u0 (
        .clk(clk), .rst_n(rst_n), .din(din), .din_en(din_en),
        .tap_sel(tap_sel), .cascade_sel(cascade_sel), .tap_load(tap_load),
        .force_min(force_min), .force_max(force_max),
        .dout(dout), .casc_out(casc_out)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", rq, act, exp, $time);
        end
    endtask

    function automatic int eff_tap();
        if (force_max) return 127;
        if (force_min) return 0;
        return int'(m_tap);
    endfunction

    // One clock edge: update the model from the stable inputs, then move to negedge.
    task automatic step();
        @(posedge clk);
        if (!rst_n) begin
            m_tap = '0; m_casc = 1'b0; m_cout = 1'b0; m_in = 1'b0;
            for (int i = 0; i < 256; i++) hist[i] = 1'b0;
            settle = 1000;
        end else begin
            m_cout = m_casc;
            if (tap_load) begin m_tap = tap_sel; m_casc = cascade_sel; end
            if (din_en) m_in = din;
            hist[wp] = m_in;
            wp = (wp + 1) % 256;
        end
        @(negedge clk);
    endtask

    // Compare dout with the history model once the effective tap has settled.
    task automatic chk_dout(input string rq);
        int e;
        logic exp_v;
        e = eff_tap();
        if (e != eff_prev) settle = 0;
        eff_prev = e;
        if (settle >= 128) begin
            exp_v = hist[(wp + 255 - e) % 256];
            chk(dout === exp_v, rq, int'(dout), int'(exp_v));
        end
        settle++;
    endtask

    // Load a setting, then run random data while changing the select inputs with load low.
    task automatic run_phase(input logic [6:0] s, input bit fmin, input bit fmax,
                             input int cycles, input int en_pct, input string rq);
        tap_sel = s; tap_load = 1'b1; force_min = fmin; force_max = fmax;
        step();
        tap_load = 1'b0;
        settle = 0;
        for (int c = 0; c < cycles; c++) begin
            din = 1'($urandom);
            din_en = (($urandom % 100) < en_pct);
            tap_sel = 7'($urandom);          // R2: ignored while load is low
            cascade_sel = 1'($urandom);
            step();
            chk_dout(rq);
            chk(casc_out === m_cout, "R6", int'(casc_out), int'(m_cout));
        end
    endtask

    // Measure edges from an accepted pulse to its appearance on dout.
    task automatic measure(input logic [6:0] s, output int lat);
        tap_sel = s; tap_load = 1'b1; force_min = 1'b0; force_max = 1'b0;
        din_en = 1'b1; din = 1'b0;
        step();
        tap_load = 1'b0;
        for (int c = 0; c < 140; c++) step();
        din = 1'b1;
        step();
        din = 1'b0;
        lat = 1;
        while (dout !== 1'b1 && lat < 300) begin
            step();
            lat++;
        end
        settle = 0;
    endtask

    initial begin
        int lat, prev_lat;
        logic held;
        logic [6:0] ladder [14];
        void'($urandom(32'd20240611));
        ladder = '{7'd0, 7'd1, 7'd2, 7'd3, 7'd7, 7'd8, 7'd15, 7'd16,
                   7'd31, 7'd32, 7'd63, 7'd64, 7'd126, 7'd127};

        // R1: reset wins over a load request
        rst_n = 1'b0; din = 1'b1; din_en = 1'b1; tap_sel = 7'h55; cascade_sel = 1'b1;
        tap_load = 1'b1; force_min = 1'b0; force_max = 1'b0;
        for (int i = 0; i < 3; i++) step();
        chk(dout === 1'b0, "R1", int'(dout), 0);
        chk(casc_out === 1'b0, "R1", int'(casc_out), 0);
        rst_n = 1'b1; tap_load = 1'b0; cascade_sel = 1'b0; din = 1'b0;
        step();
        chk(casc_out === 1'b0, "R1", int'(casc_out), 0);
        chk(dout === 1'b0, "R1", int'(dout), 0);

        // R6: cascade bit appears one edge after it is held
        cascade_sel = 1'b1; tap_load = 1'b1;
        step();
        chk(casc_out === 1'b0, "R6", int'(casc_out), 0);
        tap_load = 1'b0; cascade_sel = 1'b0;
        step();
        chk(casc_out === 1'b1, "R6", int'(casc_out), 1);
        step();
        chk(casc_out === 1'b1, "R2", int'(casc_out), 1);

        // R3 / R4: directed settings
        run_phase(7'd0,   0, 0, 300, 100, "R3");
        run_phase(7'd127, 0, 0, 300, 100, "R3");
        run_phase(7'd1,   0, 0, 300, 100, "R3");
        run_phase(7'd64,  0, 0, 300, 100, "R3");
        run_phase(7'd100, 1, 0, 300, 100, "R4");
        run_phase(7'd5,   0, 1, 300, 100, "R4");
        run_phase(7'd20,  1, 1, 300, 100, "R4");
        // R5: gated input with random enable
        run_phase(7'd10,  0, 0, 300, 50, "R5");

        // R5: directed freeze with zero tap
        run_phase(7'd0, 0, 0, 130, 100, "R5");
        din_en = 1'b0;
        step();
        held = dout;
        for (int i = 0; i < 6; i++) begin
            din = ~din;
            step();
            chk(dout === held, "R5", int'(dout), int'(held));
        end

        // Random settings (R2, R3, R4)
        for (int p = 0; p < 8; p++) begin
            run_phase(7'($urandom), (($urandom % 4) == 0), (($urandom % 5) == 0),
                      260, 85, "R3");
        end

        // R7: latency ladder
        prev_lat = 0;
        foreach (ladder[k]) begin
            measure(ladder[k], lat);
            chk(lat == int'(ladder[k]) + 1, "R3", lat, int'(ladder[k]) + 1);
            chk(lat > prev_lat, "R7", lat, prev_lat + 1);
            prev_lat = lat;
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        #600000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule